// File: doc/BRIEF.md
# Iterative Unsigned Divider with Selectable Restoring / Non-Restoring Iteration

This block divides an unsigned dividend by an unsigned divisor one quotient bit per clock. It keeps three working registers: a divisor register, a dividend register that gradually fills with quotient bits, and a partial-remainder register one bit wider than the operands so that it carries a sign. A start pulse captures both operands and the algorithm select. The iteration then runs until the quotient and remainder are ready, and a one-cycle done pulse marks the end.

Two iteration schemes are available, chosen per operation. The restoring scheme shifts, subtracts, and undoes the subtraction within the same clock when the partial remainder goes negative. The non-restoring scheme never undoes a subtraction. It adds or subtracts the divisor according to the sign of the current partial remainder, and it spends one extra clock at the end to fix a negative remainder. A zero divisor skips the iteration entirely and raises a flag.

Top module: `iter_divider`

## Requirements
- R1: While reset is low and after its release, busy, done and div_by_zero are 0 and quotient and remainder are 0.
- R2: A start seen at a clock edge while busy is low is accepted: dividend, divisor and algo_sel are captured at that edge, and for a nonzero divisor busy is 1 from that edge on.
- R3: With algo_sel = 0 (restoring), busy stays high for exactly WIDTH cycles. Then done is 1 for one cycle with quotient = floor(dividend / divisor) and remainder = dividend mod divisor. The partial remainder is never negative after a step.
- R4: With algo_sel = 1 (non-restoring), busy stays high for exactly WIDTH + 1 cycles (WIDTH steps plus one correction cycle). The result values are the same as in R3.
- R5: The non-restoring correction cycle adds the divisor back only when the partial remainder is negative, so the remainder is exact for every operand pair. Only non-restoring operations have this cycle.
- R6: done is a single-cycle pulse that never coincides with busy. quotient and remainder keep their final values until the next accepted start.
- R7: A start while busy is 1 is ignored: the running operation keeps its operands and finishes at its original time with its original result.
- R8: A zero divisor makes done and div_by_zero 1 in the cycle after the accepting edge, with quotient all ones and remainder equal to the dividend. div_by_zero returns to 0 when a later start with a nonzero divisor is accepted.
- R9: algo_sel is used only at the accepting edge; changing it while busy has no effect on the latency or the result.
- R10: Boundary operands give exact results: a dividend smaller than the divisor gives quotient 0, a divisor of 1 gives the dividend back, and all-ones operands give quotient 1 and remainder 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a division; taken when busy is low |
| algo_sel | input | 1 | 0 = restoring, 1 = non-restoring |
| dividend | input | WIDTH | Unsigned dividend |
| divisor | input | WIDTH | Unsigned divisor |
| busy | output | 1 | Iteration or correction in progress |
| done | output | 1 | One-cycle completion pulse |
| div_by_zero | output | 1 | Last accepted divisor was zero |
| quotient | output | WIDTH | Quotient, valid from done until the next start |
| remainder | output | WIDTH | Remainder, valid from done until the next start |

## Verification
The bench runs a pseudo-random sweep of operand pairs in both modes against a behavioural model that predicts busy, done, the flag and the results on every clock. Mismatches in per-mode latency therefore show up separately from mismatches in arithmetic. Directed pairs cover the cases the sweep seldom reaches: dividend below the divisor, divisor of one, all-ones operands and small divisors with large dividends. The small-divisor cases often leave the non-restoring partial remainder negative and so exercise the correction cycle. Further sequences restart while busy, flip the mode during an operation, and follow a zero divisor with a normal one, which separates operand capture, mode capture and flag clearing from the arithmetic.

// File: rtl/div_pkg.sv
package div_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2,
    ST_DONE = 2'd3
  } div_state_e;

  typedef enum logic {
    ALG_RESTORE    = 1'b0,
    ALG_NONRESTORE = 1'b1
  } div_alg_e;

endpackage

// File: rtl/div_step_unit.sv
module div_step_unit #(
  parameter int WIDTH = 8
) (
  input  logic             alg_nonrestore,
  input  logic [WIDTH:0]   a_in,
  input  logic [WIDTH-1:0] q_in,
  input  logic [WIDTH-1:0] m_in,
  output logic [WIDTH:0]   a_out,
  output logic [WIDTH-1:0] q_out
);
  localparam int AW = WIDTH + 1;
  localparam int PW = AW + WIDTH;

  // shift the pair {A,Q} left by one; returns the new A part
  function automatic logic [AW-1:0] shifted_a(input logic [AW-1:0] a,
                                              input logic [WIDTH-1:0] q);
    shifted_a = {a[AW-2:0], q[WIDTH-1]};
  endfunction

  // restoring iteration: subtract, keep or undo in the same cycle
  function automatic logic [PW-1:0] restore_step(input logic [AW-1:0] a,
                                                 input logic [WIDTH-1:0] q,
                                                 input logic [WIDTH-1:0] m);
    logic [AW-1:0] a_sh;
    logic [AW:0]   trial;
    a_sh  = shifted_a(a, q);
    trial = {1'b0, a_sh} - {2'b00, m};
    if (trial[AW]) begin
      restore_step = {a_sh, q[WIDTH-2:0], 1'b0};
    end else begin
      restore_step = {trial[AW-1:0], q[WIDTH-2:0], 1'b1};
    end
  endfunction

  // non-restoring iteration: add or subtract by the sign of the old A
  function automatic logic [PW-1:0] nonrestore_step(input logic [AW-1:0] a,
                                                    input logic [WIDTH-1:0] q,
                                                    input logic [WIDTH-1:0] m);
    logic [AW-1:0] a_sh;
    logic [AW-1:0] a_nx;
    a_sh = shifted_a(a, q);
    if (a[AW-1]) begin
      a_nx = a_sh + {1'b0, m};
    end else begin
      a_nx = a_sh - {1'b0, m};
    end
    nonrestore_step = {a_nx, q[WIDTH-2:0], ~a_nx[AW-1]};
  endfunction

  logic [PW-1:0] pair_r;
  logic [PW-1:0] pair_n;
  logic [PW-1:0] pair_sel;

  always_comb begin
    pair_r   = restore_step(a_in, q_in, m_in);
    pair_n   = nonrestore_step(a_in, q_in, m_in);
    pair_sel = alg_nonrestore ? pair_n : pair_r;
  end

  assign a_out = pair_sel[PW-1:WIDTH];
  assign q_out = pair_sel[WIDTH-1:0];

endmodule

// File: rtl/div_fix_unit.sv
module div_fix_unit #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH:0]   a_in,
  input  logic [WIDTH-1:0] m_in,
  output logic [WIDTH:0]   a_out,
  output logic             corrected
);
  localparam int AW = WIDTH + 1;

  function automatic logic [AW-1:0] fix_remainder(input logic [AW-1:0] a,
                                                  input logic [WIDTH-1:0] m);
    if (a[AW-1]) begin
      fix_remainder = a + {1'b0, m};
    end else begin
      fix_remainder = a;
    end
  endfunction

  assign a_out     = fix_remainder(a_in, m_in);
  assign corrected = a_in[AW-1];

endmodule

// File: rtl/div_sequencer.sv
module div_sequencer
  import div_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       divisor_zero,
  input  logic       alg_nonrestore,
  output div_state_e state,
  output logic       busy,
  output logic       done,
  output logic       load_fire,
  output logic       zero_fire,
  output logic       step_fire,
  output logic       fix_fire
);
  localparam int CW = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST_STEP = CW'(WIDTH - 1);

  div_state_e    state_d;
  logic [CW-1:0] step_cnt;
  logic          accept;
  logic          last_step;

  assign busy      = (state == ST_RUN) || (state == ST_FIX);
  assign done      = (state == ST_DONE);
  assign accept    = start && !busy;
  assign load_fire = accept && !divisor_zero;
  assign zero_fire = accept && divisor_zero;
  assign step_fire = (state == ST_RUN);
  assign fix_fire  = (state == ST_FIX);
  assign last_step = step_fire && (step_cnt == LAST_STEP);

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE, ST_DONE: begin
        if (load_fire) begin
          state_d = ST_RUN;
        end else if (zero_fire) begin
          state_d = ST_DONE;
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_RUN: begin
        if (last_step) begin
          state_d = alg_nonrestore ? ST_FIX : ST_DONE;
        end
      end
      ST_FIX: state_d = ST_DONE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      step_cnt <= '0;
    end else begin
      state <= state_d;
      if (load_fire) begin
        step_cnt <= '0;
      end else if (step_fire) begin
        step_cnt <= step_cnt + CW'(1);
      end
    end
  end

endmodule

// File: rtl/iter_divider.sv
module iter_divider
  import div_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             algo_sel,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic             div_by_zero,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder
);
  localparam int AW = WIDTH + 1;

  logic [WIDTH-1:0] m_reg;
  logic [WIDTH-1:0] q_reg;
  logic [AW-1:0]    a_reg;
  logic             alg_q;
  logic             dbz_q;

  div_state_e       state;
  logic             load_fire;
  logic             zero_fire;
  logic             step_fire;
  logic             fix_fire;
  logic             divisor_zero;

  logic [AW-1:0]    step_a;
  logic [WIDTH-1:0] step_q;
  logic [AW-1:0]    fix_a;
  logic             fix_corrected;

  assign divisor_zero = (divisor == '0);

  div_sequencer #(.WIDTH(WIDTH)) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (start),
    .divisor_zero   (divisor_zero),
    .alg_nonrestore (alg_q),
    .state          (state),
    .busy           (busy),
    .done           (done),
    .load_fire      (load_fire),
    .zero_fire      (zero_fire),
    .step_fire      (step_fire),
    .fix_fire       (fix_fire)
  );

  div_step_unit #(.WIDTH(WIDTH)) u_step (
    .alg_nonrestore (alg_q),
    .a_in           (a_reg),
    .q_in           (q_reg),
    .m_in           (m_reg),
    .a_out          (step_a),
    .q_out          (step_q)
  );

  div_fix_unit #(.WIDTH(WIDTH)) u_fix (
    .a_in      (a_reg),
    .m_in      (m_reg),
    .a_out     (fix_a),
    .corrected (fix_corrected)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_reg <= '0;
      q_reg <= '0;
      a_reg <= '0;
      alg_q <= ALG_RESTORE;
      dbz_q <= 1'b0;
    end else begin
      if (load_fire) begin
        m_reg <= divisor;
        q_reg <= dividend;
        a_reg <= '0;
        alg_q <= algo_sel;
        dbz_q <= 1'b0;
      end else if (zero_fire) begin
        m_reg <= '0;
        q_reg <= '1;
        a_reg <= {1'b0, dividend};
        alg_q <= algo_sel;
        dbz_q <= 1'b1;
      end else if (step_fire) begin
        a_reg <= step_a;
        q_reg <= step_q;
      end else if (fix_fire) begin
        a_reg <= fix_a;
      end
    end
  end

  assign div_by_zero = dbz_q;
  assign quotient    = q_reg;
  assign remainder   = a_reg[WIDTH-1:0];

endmodule

// File: rtl/div_checker.sv
module div_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             algo_sel,
  input logic [WIDTH-1:0] divisor,
  input logic             busy,
  input logic             done,
  input logic             div_by_zero,
  input logic [WIDTH-1:0] remainder,
  input logic [WIDTH-1:0] m_reg,
  input logic             alg_q,
  input logic             a_sign,
  input logic             step_fire,
  input logic             fix_fire,
  input logic             fix_corrected
);
  localparam int BW = $clog2(WIDTH + 3) + 1;
  localparam logic [BW-1:0] LAT_RESTORE    = BW'(WIDTH);
  localparam logic [BW-1:0] LAT_NONRESTORE = BW'(WIDTH + 1);

  logic [WIDTH-1:0] cap_div;
  logic             cap_alg;
  logic [BW-1:0]    busy_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_div  <= '0;
      cap_alg  <= 1'b0;
      busy_cnt <= '0;
    end else if (start && !busy) begin
      cap_div  <= divisor;
      cap_alg  <= algo_sel;
      busy_cnt <= '0;
    end else if (busy) begin
      busy_cnt <= busy_cnt + BW'(1);
    end
  end

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_ZERO_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && divisor == '0) |=> (done && div_by_zero)); // R8
  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_by_zero) |-> (remainder < cap_div)); // R3
  AST_RESTORE_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && !alg_q) |=> !a_sign); // R3
  AST_LATENCY_BY_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_by_zero) |-> (busy_cnt == (cap_alg ? LAT_NONRESTORE : LAT_RESTORE))); // R4
  AST_FIX_ONLY_NONRESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    fix_fire |-> alg_q); // R5
  AST_FIX_LEAVES_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
    (fix_fire && fix_corrected) |=> !a_sign); // R5
  AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(m_reg)); // R7
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (alg_q == cap_alg)); // R9

endmodule

bind iter_divider div_checker #(.WIDTH(WIDTH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start         (start),
  .algo_sel      (algo_sel),
  .divisor       (divisor),
  .busy          (busy),
  .done          (done),
  .div_by_zero   (div_by_zero),
  .remainder     (remainder),
  .m_reg         (m_reg),
  .alg_q         (alg_q),
  .a_sign        (a_reg[WIDTH]),
  .step_fire     (step_fire),
  .fix_fire      (fix_fire),
  .fix_corrected (fix_corrected)
);

// File: tb/sim_iter_divider.sv
module sim_iter_divider;
  localparam int W = 8;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG = 150000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         algo_sel = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         busy, done, div_by_zero;
  logic [W-1:0] quotient, remainder;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  iter_divider #(.WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .algo_sel(algo_sel),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .div_by_zero(div_by_zero), .quotient(quotient), .remainder(remainder)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // behavioural reference: one integer countdown and a pending result
  int m_busy, m_done, m_dbz, m_q, m_r, left, pend_q, pend_r;
  int all_ones = (1 << W) - 1;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_dbz = 0; m_q = 0; m_r = 0; left = 0;
    end else begin
      m_done = 0;
      if (m_busy != 0) begin
        left = left - 1;
        if (left == 0) begin
          m_busy = 0; m_done = 1; m_q = pend_q; m_r = pend_r;
        end
      end else if (start) begin
        if (divisor == 0) begin
          m_done = 1; m_dbz = 1; m_q = all_ones; m_r = int'(dividend);
        end else begin
          m_busy = 1; m_dbz = 0;
          left   = algo_sel ? W + 1 : W;
          pend_q = int'(dividend) / int'(divisor);
          pend_r = int'(dividend) % int'(divisor);
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // per-clock comparison with the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(int'(busy) == m_busy, "R2 busy vs model", int'(busy), m_busy);
      chk(int'(done) == m_done, "R6 done vs model", int'(done), m_done);
      chk(int'(div_by_zero) == m_dbz, "R8 flag vs model", int'(div_by_zero), m_dbz);
      if (m_busy == 0) begin
        chk(int'(quotient) == m_q, "R3 quotient vs model", int'(quotient), m_q);
        chk(int'(remainder) == m_r, "R3 remainder vs model", int'(remainder), m_r);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
      finish_run();
    end
  end

  task automatic launch(input logic [W-1:0] x, input logic [W-1:0] y, input logic md);
    @(negedge clk);
    while (busy) @(negedge clk);
    start = 1'b1; dividend = x; divisor = y; algo_sel = md;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    for (int n = 0; n < 64 && !done; n++) @(negedge clk);
  endtask

  task automatic check_result(input logic [W-1:0] x, input logic [W-1:0] y, input string tag);
    int eq, er;
    eq = (y == 0) ? all_ones : int'(x) / int'(y);
    er = (y == 0) ? int'(x) : int'(x) % int'(y);
    chk(done == 1'b1, {tag, " done"}, int'(done), 1);
    chk(int'(quotient) == eq, {tag, " quotient"}, int'(quotient), eq);
    chk(int'(remainder) == er, {tag, " remainder"}, int'(remainder), er);
  endtask

  task automatic div_op(input logic [W-1:0] x, input logic [W-1:0] y,
                        input logic md, input string tag);
    launch(x, y, md);
    wait_done();
    check_result(x, y, tag);
  endtask

  initial begin
    int seed;
    int bcount;
    logic [W-1:0] hq, hr;
    seed = 32'h1234_5678;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(busy == 0 && done == 0 && div_by_zero == 0, "R1 reset status", int'({busy, done, div_by_zero}), 0);
    chk(quotient == 0 && remainder == 0, "R1 reset data", int'({quotient, remainder}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && done == 0, "R1 after release", int'({busy, done}), 0);

    // R3 / R4 / R5: directed pairs in both modes
    for (int md = 0; md < 2; md++) begin
      div_op(8'd200, 8'd7, md[0], md ? "R4 200/7" : "R3 200/7");
      div_op(8'd255, 8'd2, md[0], "R5 small divisor");
      div_op(8'd129, 8'd3, md[0], "R5 odd split");
      div_op(8'd5, 8'd9, md[0], "R10 dividend below divisor");
      div_op(8'd173, 8'd1, md[0], "R10 divisor one");
      div_op(8'd255, 8'd255, md[0], "R10 all ones");
      div_op(8'd0, 8'd13, md[0], "R10 zero dividend");
      div_op(8'd254, 8'd255, md[0], "R10 just below");
    end

    // R3 / R4: pseudo-random sweep, both modes
    for (int i = 0; i < 300; i++) begin
      logic [W-1:0] x, y;
      seed = seed * 1103515245 + 12345;
      x = seed[23:16];
      y = seed[15:8] >> seed[3:1];
      if (y == 0) y = 8'd1;
      div_op(x, y, seed[30], seed[30] ? "R4 sweep" : "R3 sweep");
    end

    // R6: results held after done
    div_op(8'd100, 8'd6, 1'b0, "R6 base");
    hq = quotient; hr = remainder;
    repeat (4) @(negedge clk);
    chk(done == 0, "R6 done pulse ended", int'(done), 0);
    chk(quotient == hq && remainder == hr, "R6 values held", int'({quotient, remainder}), int'({hq, hr}));

    // R7: start while busy is ignored
    launch(8'd250, 8'd11, 1'b1);
    start = 1'b1; dividend = 8'd9; divisor = 8'd2; algo_sel = 1'b0;
    repeat (3) @(negedge clk);
    start = 1'b0;
    wait_done();
    check_result(8'd250, 8'd11, "R7 restart ignored");

    // R9: mode flipped during run
    launch(8'd77, 8'd5, 1'b0);
    bcount = 1;
    algo_sel = 1'b1;
    while (busy && bcount < 40) begin @(negedge clk); if (busy) bcount++; end
    chk(bcount == W, "R9 latency kept restoring", bcount, W);
    check_result(8'd77, 8'd5, "R9 result");

    launch(8'd77, 8'd5, 1'b1);
    bcount = 1;
    algo_sel = 1'b0;
    while (busy && bcount < 40) begin @(negedge clk); if (busy) bcount++; end
    chk(bcount == W + 1, "R4 latency non-restoring", bcount, W + 1);

    // R8: zero divisor then a normal division
    launch(8'd42, 8'd0, 1'b0);
    chk(done == 1 && div_by_zero == 1, "R8 done next cycle", int'({done, div_by_zero}), 3);
    check_result(8'd42, 8'd0, "R8 zero result");
    launch(8'd42, 8'd0, 1'b1);
    check_result(8'd42, 8'd0, "R8 zero non-restoring");
    launch(8'd42, 8'd4, 1'b0);
    chk(div_by_zero == 0, "R8 flag cleared", int'(div_by_zero), 0);
    wait_done();
    check_result(8'd42, 8'd4, "R8 recovery");

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule